// File: doc/BRIEF.md
# Single-Lane Flash Command Sequencer

This block sends one short command to a serial flash device over a one-bit SPI link and collects the reply. Software packs the whole command into one control word: an 8-bit opcode, plus an optional address phase, an optional write phase and an optional read phase. Each optional phase has an enable flag and a byte count stored as the count minus one. The address comes from its own register and the outgoing data from a write-data register. Reply bytes land in two 32-bit result words.

The host writes to the block through a plain register write port. Setting bit 0 of the control word starts the command. A busy flag stays high from the cycle after that write until the last serial clock period ends. Chip select is held low for exactly that time. While a command runs, every register write is dropped. There is no streaming interface, because each command moves at most eight reply bytes. The serial clock comes from an internal divider whose half-period, in system clock cycles, is a parameter.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, cmd_busy=0, spi_cs_n=1, spi_sclk=0, spi_mosi=0, and both rdata words are zero.
- R2: The control word (cfg_sel=0) is decoded as follows. Opcode is bits 31:24. Read enable is bit 23, and read count minus one is bits 22:20. Address enable is bit 19, and address count minus one is bits 17:16. Write enable is bit 15, and write count minus one is bits 13:12 (bit 14 is ignored). A count value of 0 means one byte. When the block is idle, a control write with bit 0 set starts the command, and cmd_busy reads 1 from the next cycle on.
- R3: Bits go out in this phase order: opcode, address, write data, read. Each byte is sent MSB first. spi_mosi is 0 during the read phase and whenever the block is idle.
- R4: The address is taken from the address register (cfg_sel=1). It is sent starting at the most significant byte in use (byte count minus one) and ending at byte 0.
- R5: Write bytes are taken from the write-data register (cfg_sel=2), starting at byte 0 (bits 7:0) and moving upward.
- R6: Read bits are sampled from spi_miso on each rising edge of spi_sclk and assembled MSB first. Reply byte j goes to bits 8j+7:8j of {rdata_hi, rdata_lo}, and bytes beyond the count read as zero. Both words change only in the cycle in which the command ends. A command without a read phase leaves them unchanged.
- R7: The serial clock idles low (SPI mode 0). Each bit holds spi_sclk low for HALF_DIV cycles and then high for HALF_DIV cycles. spi_mosi changes only when the command starts or when spi_sclk falls.
- R8: spi_cs_n is low exactly while cmd_busy is 1. A command of N bytes keeps cmd_busy high for 16*HALF_DIV*N cycles. The block goes idle on the falling edge of the last bit.
- R9: Writes to any register while cmd_busy is 1 are ignored. This covers execute requests, address writes and write-data writes.
- R10: A control write with bit 0 clear, or any write with cfg_sel=3, starts nothing and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 address, 2 write data, 3 none |
| cfg_wdata | input | 32 | Register write data |
| cmd_busy | output | 1 | Command in progress |
| rdata_lo | output | 32 | Reply bytes 0 to 3 |
| rdata_hi | output | 32 | Reply bytes 4 to 7 |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong phase, byte index or bit counter shows up on spi_mosi. It appears within one serial bit period (2*HALF_DIV cycles) of the bad transition, and every such transition is compared cycle by cycle. A divider fault shows up on spi_sclk or in the length of cmd_busy within half a bit. A capture fault only shows up in rdata_lo and rdata_hi in the cycle the command ends, so every read command is checked for all eight result bytes, including those that must read as zero.

// File: rtl/fce_pkg.sv
package fce_pkg;

  localparam int OPC_LSB    = 24;
  localparam int RD_EN_BIT  = 23;
  localparam int RD_CNT_LSB = 20;
  localparam int AD_EN_BIT  = 19;
  localparam int AD_CNT_LSB = 16;
  localparam int WR_EN_BIT  = 15;
  localparam int WR_CNT_LSB = 12;
  localparam int GO_BIT     = 0;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_OPC  = 3'd1,
    PH_ADDR = 3'd2,
    PH_WDAT = 3'd3,
    PH_RDAT = 3'd4
  } phase_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic       rd_en;
    logic [2:0] rd_cnt;
    logic       ad_en;
    logic [1:0] ad_cnt;
    logic       wr_en;
    logic [1:0] wr_cnt;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [31:0] w);
    cmd_t c;
    c.opcode = w[OPC_LSB +: 8];
    c.rd_en  = w[RD_EN_BIT];
    c.rd_cnt = w[RD_CNT_LSB +: 3];
    c.ad_en  = w[AD_EN_BIT];
    c.ad_cnt = w[AD_CNT_LSB +: 2];
    c.wr_en  = w[WR_EN_BIT];
    c.wr_cnt = w[WR_CNT_LSB +: 2];
    return c;
  endfunction

  function automatic phase_e next_phase(input phase_e cur, input cmd_t c);
    phase_e n;
    n = PH_IDLE;
    case (cur)
      PH_OPC:  n = c.ad_en ? PH_ADDR : c.wr_en ? PH_WDAT : c.rd_en ? PH_RDAT : PH_IDLE;
      PH_ADDR: n = c.wr_en ? PH_WDAT : c.rd_en ? PH_RDAT : PH_IDLE;
      PH_WDAT: n = c.rd_en ? PH_RDAT : PH_IDLE;
      default: n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/fce_clkgen.sv
module fce_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int HCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HCW-1:0] HC_LAST = HCW'(HALF_DIV - 1);

  logic [HCW-1:0] hc_q;
  logic           sclk_q;
  logic           wrap;

  assign wrap = active && (hc_q == HC_LAST);
  assign rise = wrap && !sclk_q;
  assign fall = wrap && sclk_q;
  assign sclk = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc_q   <= '0;
      sclk_q <= 1'b0;
    end else if (!active || fall) begin
      hc_q   <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      hc_q   <= '0;
      sclk_q <= 1'b1;
    end else begin
      hc_q   <= hc_q + 1'b1;
    end
  end
endmodule

// File: rtl/fce_sequencer.sv
module fce_sequencer
  import fce_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [7:0]   start_opcode,
  input  cmd_t         cmd,
  input  logic [31:0]  addr,
  input  logic [31:0]  wdata,
  input  logic         fall,
  output phase_e       phase,
  output logic [2:0]   bit_idx,
  output logic [2:0]   byte_idx,
  output logic         mosi,
  output logic         done
);
  phase_e     ph_q, nph;
  logic [7:0] sh_q, nbyte;
  logic [2:0] bit_q, byte_q, nidx;
  logic       last_byte;
  logic [1:0] asel;

  always_comb begin
    case (ph_q)
      PH_ADDR: last_byte = (byte_q[1:0] == cmd.ad_cnt);
      PH_WDAT: last_byte = (byte_q[1:0] == cmd.wr_cnt);
      PH_RDAT: last_byte = (byte_q == cmd.rd_cnt);
      default: last_byte = 1'b1;
    endcase
    nph  = last_byte ? next_phase(ph_q, cmd) : ph_q;
    nidx = last_byte ? 3'd0 : byte_q + 3'd1;
    asel = cmd.ad_cnt - nidx[1:0];
    case (nph)
      PH_ADDR: nbyte = addr[8*asel +: 8];
      PH_WDAT: nbyte = wdata[8*nidx[1:0] +: 8];
      default: nbyte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      sh_q   <= 8'h00;
      bit_q  <= 3'd0;
      byte_q <= 3'd0;
    end else if (start) begin
      ph_q   <= PH_OPC;
      sh_q   <= start_opcode;
      bit_q  <= 3'd0;
      byte_q <= 3'd0;
    end else if (fall) begin
      if (bit_q == 3'd7) begin
        ph_q   <= nph;
        byte_q <= nidx;
        sh_q   <= nbyte;
        bit_q  <= 3'd0;
      end else begin
        sh_q  <= {sh_q[6:0], 1'b0};
        bit_q <= bit_q + 3'd1;
      end
    end
  end

  assign phase    = ph_q;
  assign bit_idx  = bit_q;
  assign byte_idx = byte_q;
  assign mosi     = sh_q[7];
  assign done     = fall && (bit_q == 3'd7) && (nph == PH_IDLE);
endmodule

// File: rtl/fce_capture.sv
module fce_capture #(
  parameter int NBYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rise,
  input  logic        in_read,
  input  logic [2:0]  bit_idx,
  input  logic [2:0]  byte_idx,
  input  logic        miso,
  input  logic        done,
  input  logic        commit_en,
  output logic [8*NBYTES-1:0] rdata
);
  logic [7:0]          cap_q [NBYTES];
  logic [6:0]          rxsh_q;
  logic [8*NBYTES-1:0] cap_flat;
  logic [8*NBYTES-1:0] rdata_q;

  for (genvar j = 0; j < NBYTES; j++) begin : g_pack
    assign cap_flat[8*j +: 8] = cap_q[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      rxsh_q <= 7'd0;
      for (int j = 0; j < NBYTES; j++) cap_q[j] <= 8'h00;
    end else if (rise && in_read) begin
      rxsh_q <= {rxsh_q[5:0], miso};
      if (bit_idx == 3'd7) cap_q[byte_idx] <= {rxsh_q, miso};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 rdata_q <= '0;
    else if (done && commit_en) rdata_q <= cap_flat;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic        cmd_busy,
  output logic [31:0] rdata_lo,
  output logic [31:0] rdata_hi,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int RD_BYTES = 8;

  cmd_t        cmd_q;
  logic [31:0] addr_q, wd_q;
  phase_e      phase;
  logic [2:0]  bit_idx, byte_idx;
  logic        busy, start, rise, fall, done;
  logic [8*RD_BYTES-1:0] rd_all;

  assign busy  = (phase != PH_IDLE);
  assign start = cfg_we && !busy && (cfg_sel == 2'd0) && cfg_wdata[GO_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (cfg_we && !busy) begin
      case (cfg_sel)
        2'd0:    if (cfg_wdata[GO_BIT]) cmd_q <= decode_cmd(cfg_wdata);
        2'd1:    addr_q <= cfg_wdata;
        2'd2:    wd_q   <= cfg_wdata;
        default: ;
      endcase
    end
  end

  fce_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .active(busy),
    .sclk(spi_sclk), .rise(rise), .fall(fall)
  );

  fce_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_opcode(cfg_wdata[OPC_LSB +: 8]), .cmd(cmd_q),
    .addr(addr_q), .wdata(wd_q), .fall(fall),
    .phase(phase), .bit_idx(bit_idx), .byte_idx(byte_idx),
    .mosi(spi_mosi), .done(done)
  );

  fce_capture #(.NBYTES(RD_BYTES)) u_cap (
    .clk(clk), .rst_n(rst_n), .start(start), .rise(rise),
    .in_read(phase == PH_RDAT), .bit_idx(bit_idx), .byte_idx(byte_idx),
    .miso(spi_miso), .done(done), .commit_en(cmd_q.rd_en),
    .rdata(rd_all)
  );

  assign cmd_busy = busy;
  assign spi_cs_n = !busy;
  assign rdata_lo = rd_all[31:0];
  assign rdata_hi = rd_all[63:32];
endmodule

// File: rtl/fce_checker.sv
module fce_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [1:0]  cfg_sel,
  input logic [31:0] cfg_wdata,
  input logic        cmd_busy,
  input logic [31:0] rdata_lo,
  input logic [31:0] rdata_hi,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic        spi_mosi
);
  // R7: data only moves while the serial clock is low
  a_r7_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  // R8: nothing toggles and chip select is released when idle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_busy |-> (!spi_sclk && !spi_mosi && spi_cs_n));

  // R9 / R2: a command only starts from an execute write
  a_r9_start_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_busy) |-> $past(cfg_we && cfg_sel == 2'd0 && cfg_wdata[0]));

  // R6: result words move only as a command ends
  a_r6_rdata_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({rdata_hi, rdata_lo}) |-> $fell(cmd_busy));

  // R7: the serial clock only rises inside a command
  a_r7_sclk_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> cmd_busy);
endmodule

bind flash_cmd_engine fce_checker u_fce_checker (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .cmd_busy(cmd_busy), .rdata_lo(rdata_lo),
  .rdata_hi(rdata_hi), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi)
);

// File: tb/flash_cmd_engine_bench.sv
module flash_cmd_engine_bench;
  localparam int HD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        spi_miso = 1'b0;
  logic        cmd_busy, spi_sclk, spi_cs_n, spi_mosi;
  logic [31:0] rdata_lo, rdata_hi;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R3";

  always #5 clk = ~clk;

  flash_cmd_engine #(.HALF_DIV(HD)) u_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cmd_busy(cmd_busy), .rdata_lo(rdata_lo),
    .rdata_hi(rdata_hi), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // flash-side responder: next reply bit after each rising serial clock
  bit resp [0:191];
  int rcnt = 0;
  always @(negedge spi_cs_n) begin rcnt = 0; spi_miso = resp[0]; end
  always @(posedge spi_sclk) begin rcnt++; spi_miso = resp[rcnt]; end

  // behavioural reference model
  bit          m_busy = 0;
  int          t = 0;
  int          nbits = 0;
  int          rfirst = 0;
  int          nrd = 0;
  bit          bits [$];
  logic [31:0] m_addr = 0, m_wd = 0;
  logic [63:0] m_rd = 0;

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bits.push_back(b[i]);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; t = 0; m_addr = 0; m_wd = 0; m_rd = 0;
    end else if (m_busy) begin
      t++;
      if (t == 2 * HD * nbits) begin
        m_busy = 0;
        if (nrd > 0) begin
          m_rd = 0;
          for (int j = 0; j < nrd; j++)
            for (int b = 0; b < 8; b++)
              m_rd[8*j + 7 - b] = resp[rfirst + 8*j + b];
        end
      end
    end else if (cfg_we) begin
      if (cfg_sel == 2'd1) m_addr = cfg_wdata;
      else if (cfg_sel == 2'd2) m_wd = cfg_wdata;
      else if (cfg_sel == 2'd0 && cfg_wdata[0]) begin
        bits.delete();
        push_byte(cfg_wdata[31:24]);
        if (cfg_wdata[19])
          for (int k = int'(cfg_wdata[17:16]); k >= 0; k--) push_byte(m_addr[8*k +: 8]);
        if (cfg_wdata[15])
          for (int k = 0; k <= int'(cfg_wdata[13:12]); k++) push_byte(m_wd[8*k +: 8]);
        rfirst = bits.size();
        nrd = cfg_wdata[23] ? int'(cfg_wdata[22:20]) + 1 : 0;
        for (int k = 0; k < nrd; k++) push_byte(8'h00);
        nbits = bits.size();
        m_busy = 1; t = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit es, em;
      es = m_busy && ((t % (2*HD)) >= HD);
      em = m_busy ? bits[t / (2*HD)] : 1'b0;
      chk(cmd_busy == m_busy, "R8", "busy", 64'(cmd_busy), 64'(m_busy));
      chk(spi_cs_n == !m_busy, "R8", "cs_n", 64'(spi_cs_n), 64'(!m_busy));
      chk(spi_sclk == es, "R7", "sclk", 64'(spi_sclk), 64'(es));
      chk(spi_mosi == em, cur_req, "mosi", 64'(spi_mosi), 64'(em));
      chk({rdata_hi, rdata_lo} == m_rd, "R6", "rdata", {rdata_hi, rdata_lo}, m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fill_resp();
    for (int i = 0; i < 192; i++) resp[i] = 1'($urandom & 1);
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input logic [7:0] op, input bit rd, input int rn,
                                      input bit ad, input int an, input bit wen, input int wn);
    logic [31:0] w;
    w = 32'd1;
    w[31:24] = op;
    w[23] = rd; w[22:20] = 3'(rn - 1);
    w[19] = ad; w[17:16] = 2'(an - 1);
    w[15] = wen; w[13:12] = 2'(wn - 1);
    return w;
  endfunction

  initial begin
    logic [63:0] saved;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!cmd_busy && spi_cs_n && !spi_sclk && !spi_mosi, "R1", "ctl outputs",
        {cmd_busy, spi_cs_n, spi_sclk, spi_mosi}, 64'b0100);
    chk({rdata_hi, rdata_lo} == 64'd0, "R1", "rdata", {rdata_hi, rdata_lo}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R3: opcode only
    cur_req = "R3"; fill_resp();
    @(negedge clk); cfg_we = 1; cfg_sel = 0; cfg_wdata = ctl(8'h06, 0, 1, 0, 1, 0, 1);
    @(negedge clk); cfg_we = 0;
    chk(cmd_busy === 1'b1, "R2", "busy after execute", 64'(cmd_busy), 64'd1);
    wait_idle();

    // R4: three address bytes
    cur_req = "R4";
    wr(2'd1, 32'h1234_5678);
    wr(2'd0, ctl(8'hD8, 0, 1, 1, 3, 0, 1));
    wait_idle();

    // R5: four address bytes and two write bytes
    cur_req = "R5";
    wr(2'd1, 32'hA1B2_C3D4);
    wr(2'd2, 32'h99E7_5AC3);
    wr(2'd0, ctl(8'h02, 0, 1, 1, 4, 1, 2));
    wait_idle();

    // R6: eight read bytes
    cur_req = "R6"; fill_resp();
    wr(2'd0, ctl(8'h9F, 1, 8, 0, 1, 0, 1));
    wait_idle();
    chk({rdata_hi, rdata_lo} == m_rd, "R6", "8-byte read", {rdata_hi, rdata_lo}, m_rd);

    // R6: three read bytes, upper bytes zero
    fill_resp();
    wr(2'd0, ctl(8'h05, 1, 3, 0, 1, 0, 1));
    wait_idle();
    chk(rdata_hi == 32'd0 && rdata_lo[31:24] == 8'd0, "R6", "unused bytes zero",
        {rdata_hi, rdata_lo}, m_rd);

    // R6: five bytes after address and four write bytes
    cur_req = "R3"; fill_resp();
    wr(2'd1, 32'h0000_0042);
    wr(2'd2, 32'hDEAD_BEEF);
    wr(2'd0, ctl(8'h4B, 1, 5, 1, 1, 1, 4));
    wait_idle();
    saved = {rdata_hi, rdata_lo};

    // R6: a command without a read keeps the result words
    wr(2'd0, ctl(8'h04, 0, 1, 0, 1, 0, 1));
    wait_idle();
    chk({rdata_hi, rdata_lo} == saved, "R6", "no-read keeps rdata", {rdata_hi, rdata_lo}, saved);

    // R9: writes while busy are dropped
    cur_req = "R9"; fill_resp();
    wr(2'd1, 32'h00C0_FFEE);
    wr(2'd0, ctl(8'h20, 0, 1, 1, 3, 0, 1));
    wr(2'd1, 32'h0011_2233);
    wr(2'd2, 32'h5555_5555);
    wr(2'd0, ctl(8'hFF, 1, 8, 1, 4, 1, 4));
    wait_idle();
    chk(!cmd_busy, "R9", "no restart after busy write", 64'(cmd_busy), 64'd0);
    wr(2'd0, ctl(8'h21, 0, 1, 1, 3, 0, 1));
    wait_idle();
    chk(m_addr == 32'h00C0_FFEE, "R9", "address kept", 64'(m_addr), 64'h00C0FFEE);

    // R10: writes that start nothing
    cur_req = "R10";
    wr(2'd0, 32'h9F80_0000);
    wr(2'd3, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    chk(!cmd_busy && spi_cs_n, "R10", "no start", {cmd_busy, spi_cs_n}, 64'b01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule